// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block brings gated power domains up and down in a fixed safe order. It owns three shared control vectors: a power-switch vector, an isolation vector and a domain-reset vector. Each domain has a configured mask for each vector, and only the bits in that mask are touched when the domain is sequenced. A power-off request engages isolation, asserts the domain reset and then removes power. A power-on request applies power, releases the reset and then releases isolation.

Software issues one request at a time by naming a domain and a direction. The controller masks are captured when the request is accepted. The controller then walks the three step slots, waiting a programmable settle time after every step it performs. It reports busy while it works and gives a one-cycle done pulse when the sequence ends. A request that arrives while the controller is busy is dropped and recorded in a sticky error flag. The on/off state of every domain is read back from the power vector.

Top module: `pwr_dom_seq`

## Requirements
- R1: After reset the power vector is all 0 (every domain powered), the isolation and reset vectors are all 1 (released), busy, done and err are 0, and every dom_on bit is 1.
- R2: A power-off request first clears the domain's isolation mask bits, then clears its reset mask bits, then sets its power mask bits. Each of these happens in its own step, in that order.
- R3: A power-on request first clears the domain's power mask bits, then sets its reset mask bits, then sets its isolation mask bits. Each of these happens in its own step, in that order.
- R4: Polarities: a power bit of 1 means powered down, an isolation bit of 0 means isolators engaged, and a reset bit of 0 means the unit is held in reset.
- R5: The isolation step and the reset step are skipped when the domain's mask for them is zero, and each skipped slot costs one cycle. The power step is always performed, even with an empty mask.
- R6: A sequence changes only the bits selected by the active domain's masks. All other bits of the three vectors keep their values, and no vector changes outside a step.
- R7: With settle value S, a performed step that is not the last is followed by S+2 cycles before the next step slot acts. A full sequence with no skips puts done high 5+2S cycles after the accepting clock edge.
- R8: busy is 1 from the cycle after a request is accepted until the final step completes. done is high for exactly one cycle, in the cycle in which the final vector values first appear, and busy is 0 in that cycle.
- R9: A request made while busy has no effect on the vectors and sets the sticky err flag. err_clr clears err, but a dropped request in the same cycle keeps err set.
- R10: dom_on[d] is 1 exactly when none of domain d's power mask bits is set in the power vector. A domain with an empty power mask always reports on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled at the clock edge |
| req_on | input | 1 | 1 = power-on request, 0 = power-off request |
| req_dom | input | DOM_W | Index of the domain to sequence |
| err_clr | input | 1 | Clears the sticky error flag |
| settle | input | CNT_W | Settle cycle count S inserted after each performed step |
| pwr_mask_cfg | input | NUM_DOM*VEC_W | Power masks, domain d at bits d*VEC_W upward |
| iso_mask_cfg | input | NUM_DOM*VEC_W | Isolation masks, same packing |
| rst_mask_cfg | input | NUM_DOM*VEC_W | Reset masks, same packing |
| pwr_vec | output | VEC_W | Power-switch vector (1 = off) |
| iso_vec | output | VEC_W | Isolation vector (0 = engaged) |
| rst_vec | output | VEC_W | Domain reset vector (0 = held) |
| dom_on | output | NUM_DOM | Per-domain powered status |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at sequence end |
| err | output | 1 | Sticky dropped-request flag |

## Verification
The bench stamps the cycle in which each vector first changes. This catches a design that swaps the isolation and reset steps, or performs them in the same cycle. Domains with empty isolation and reset masks check that skipped slots cost exactly one cycle. A design that waits out the settle time for an empty step would be late, and one that drops the power step for an empty power mask would be early. Domains that share no bits are sequenced one after another, so a design that writes whole vectors instead of masked bits corrupts a neighbour's state. A request injected mid-sequence checks that a design which accepts it, or forgets the error flag, is caught. The check looks at the victim domain's bits and at err.

// File: rtl/pds_pkg.sv
package pds_pkg;

  typedef enum logic [1:0] {K_PWR, K_RST, K_ISO} step_kind_e;
  typedef enum logic [1:0] {S_IDLE, S_STEP, S_WAIT} seq_state_e;

  // Which vector the slot idx acts on, per direction.
  function automatic step_kind_e kind_of(input logic dir_on, input logic [1:0] idx);
    step_kind_e k;
    case (idx)
      2'd0:    k = dir_on ? K_PWR : K_ISO;
      2'd1:    k = K_RST;
      default: k = dir_on ? K_ISO : K_PWR;
    endcase
    return k;
  endfunction

  // Whether the selected bits go to 1 (otherwise to 0).
  function automatic logic drive_high(input logic dir_on, input step_kind_e k);
    return dir_on ^ (k == K_PWR);
  endfunction

endpackage

// File: rtl/pds_vec_reg.sv
module pds_vec_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic         set,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);

  function automatic logic [W-1:0] apply(input logic [W-1:0] v, input logic [W-1:0] m,
                                         input logic s);
    return s ? (v | m) : (v & ~m);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else if (we) q <= apply(q, mask, set);
  end

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R6
  AST_VEC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((q ^ $past(q)) & ~$past(mask)) == '0); // R6

endmodule

// File: rtl/pds_timer.sv
module pds_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/pds_status.sv
module pds_status #(
  parameter int NUM_DOM = 4,
  parameter int VEC_W   = 8
) (
  input  logic [VEC_W-1:0]         pwr_vec,
  input  logic [NUM_DOM*VEC_W-1:0] pwr_mask_cfg,
  output logic [NUM_DOM-1:0]       dom_on
);

  function automatic logic is_on(input logic [VEC_W-1:0] v, input logic [VEC_W-1:0] m);
    return (v & m) == '0;
  endfunction

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    assign dom_on[d] = is_on(pwr_vec, pwr_mask_cfg[d*VEC_W +: VEC_W]);
  end

endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
  import pds_pkg::*;
#(
  parameter int NUM_DOM = 4,
  parameter int VEC_W   = 8,
  parameter int CNT_W   = 8,
  localparam int DOM_W  = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1,
  localparam int CFG_W  = NUM_DOM * VEC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_on,
  input  logic [DOM_W-1:0] req_dom,
  input  logic             err_clr,
  input  logic [CNT_W-1:0] settle,
  input  logic [CFG_W-1:0] pwr_mask_cfg,
  input  logic [CFG_W-1:0] iso_mask_cfg,
  input  logic [CFG_W-1:0] rst_mask_cfg,
  output logic [VEC_W-1:0] pwr_vec,
  output logic [VEC_W-1:0] iso_vec,
  output logic [VEC_W-1:0] rst_vec,
  output logic [NUM_DOM-1:0] dom_on,
  output logic             busy,
  output logic             done,
  output logic             err
);

  seq_state_e       state;
  logic [1:0]       idx;
  logic             dir_on;
  logic [VEC_W-1:0] m_pwr, m_iso, m_rst;
  logic             done_q, err_q;

  // Named internal events
  step_kind_e       cur_kind;
  logic [VEC_W-1:0] cur_mask;
  logic             in_step, skip, last, step_fire, step_set;
  logic             accept, drop, tmr_load, tmr_expired;
  logic             pwr_we, iso_we, rst_we;

  always_comb begin
    cur_kind = kind_of(dir_on, idx);
    case (cur_kind)
      K_PWR:   cur_mask = m_pwr;
      K_RST:   cur_mask = m_rst;
      default: cur_mask = m_iso;
    endcase
  end

  assign in_step   = (state == S_STEP);
  assign skip      = (cur_kind != K_PWR) && (cur_mask == '0);
  assign last      = (idx == 2'd2);
  assign step_fire = in_step && !skip;
  assign step_set  = drive_high(dir_on, cur_kind);
  assign accept    = req_valid && (state == S_IDLE);
  assign drop      = req_valid && (state != S_IDLE);
  assign tmr_load  = step_fire && !last;
  assign pwr_we    = step_fire && (cur_kind == K_PWR);
  assign iso_we    = step_fire && (cur_kind == K_ISO);
  assign rst_we    = step_fire && (cur_kind == K_RST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      idx    <= 2'd0;
      dir_on <= 1'b0;
      m_pwr  <= '0;
      m_iso  <= '0;
      m_rst  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (err_clr) err_q <= 1'b0;
      if (drop)    err_q <= 1'b1;
      case (state)
        S_IDLE: if (accept) begin
          state  <= S_STEP;
          idx    <= 2'd0;
          dir_on <= req_on;
          m_pwr  <= pwr_mask_cfg[int'(req_dom)*VEC_W +: VEC_W];
          m_iso  <= iso_mask_cfg[int'(req_dom)*VEC_W +: VEC_W];
          m_rst  <= rst_mask_cfg[int'(req_dom)*VEC_W +: VEC_W];
        end
        S_STEP: begin
          if (last) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            idx   <= idx + 2'd1;
            state <= skip ? S_STEP : S_WAIT;
          end
        end
        S_WAIT: if (tmr_expired) state <= S_STEP;
        default: state <= S_IDLE;
      endcase
    end
  end

  pds_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(settle), .expired(tmr_expired)
  );

  pds_vec_reg #(.W(VEC_W), .RST_VAL('0)) u_pwr (
    .clk(clk), .rst_n(rst_n), .we(pwr_we), .set(step_set), .mask(m_pwr), .q(pwr_vec)
  );
  pds_vec_reg #(.W(VEC_W), .RST_VAL('1)) u_iso (
    .clk(clk), .rst_n(rst_n), .we(iso_we), .set(step_set), .mask(m_iso), .q(iso_vec)
  );
  pds_vec_reg #(.W(VEC_W), .RST_VAL('1)) u_rst (
    .clk(clk), .rst_n(rst_n), .we(rst_we), .set(step_set), .mask(m_rst), .q(rst_vec)
  );

  pds_status #(.NUM_DOM(NUM_DOM), .VEC_W(VEC_W)) u_status (
    .pwr_vec(pwr_vec), .pwr_mask_cfg(pwr_mask_cfg), .dom_on(dom_on)
  );

  assign busy = (state != S_IDLE);
  assign done = done_q;
  assign err  = err_q;

  AST_NO_STEP_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !step_fire |=> ($stable(pwr_vec) && $stable(iso_vec) && $stable(rst_vec))); // R6
  AST_OFF_ISO_BEFORE_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !dir_on && cur_kind == K_PWR) |->
      ((iso_vec & m_iso) == '0 && (rst_vec & m_rst) == '0)); // R2
  AST_ON_PWR_BEFORE_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && dir_on && cur_kind == K_ISO) |->
      ((pwr_vec & m_pwr) == '0 && (rst_vec & m_rst) == m_rst)); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_DROP_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && busy) |=> err); // R9

endmodule

// File: tb/sim_pwr_dom_seq.sv
module sim_pwr_dom_seq;

  localparam int ND = 4;
  localparam int VW = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_on = 1'b0, err_clr = 1'b0;
  logic [1:0] req_dom = '0;
  logic [CW-1:0] settle = '0;
  logic [ND*VW-1:0] pwr_cfg, iso_cfg, rst_cfg;
  logic [VW-1:0] pwr_vec, iso_vec, rst_vec;
  logic [ND-1:0] dom_on;
  logic busy, done, err;

  logic [VW-1:0] mp [ND];
  logic [VW-1:0] mi [ND];
  logic [VW-1:0] mr [ND];
  logic [VW-1:0] bp, bi, br;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pwr_dom_seq #(.NUM_DOM(ND), .VEC_W(VW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_on(req_on), .req_dom(req_dom),
    .err_clr(err_clr), .settle(settle), .pwr_mask_cfg(pwr_cfg), .iso_mask_cfg(iso_cfg),
    .rst_mask_cfg(rst_cfg), .pwr_vec(pwr_vec), .iso_vec(iso_vec), .rst_vec(rst_vec),
    .dom_on(dom_on), .busy(busy), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    logic [ND-1:0] exp_on;
    for (int d = 0; d < ND; d++) exp_on[d] = ((bp & mp[d]) == '0);
    chk(pwr_vec == bp, {tag, " R4 pwr_vec"}, pwr_vec, bp);
    chk(iso_vec == bi, {tag, " R4 iso_vec"}, iso_vec, bi);
    chk(rst_vec == br, {tag, " R4 rst_vec"}, rst_vec, br);
    chk(dom_on == exp_on, {tag, " R10 dom_on"}, dom_on, exp_on);
  endtask

  // One sequence, with vector change stamps compared to the expected slot timing.
  task automatic run_seq(input int dom, input bit on, input int s, input bit inject,
                         input string tag);
    int t, lat, k;
    int ep, ei, er, gp, gi, gr;
    logic [VW-1:0] np, ni, nr, pp, pi, pr;
    bit seen;
    t = 0; ep = -1; ei = -1; er = -1;
    for (int ix = 0; ix < 3; ix++) begin
      int kind; bit perf;
      kind = (ix == 1) ? 1 : (((ix == 0) == on) ? 0 : 2); // 0 pwr, 1 rst, 2 iso
      perf = (kind == 0) || (kind == 1 && mr[dom] != '0) || (kind == 2 && mi[dom] != '0);
      t++;
      if (perf && kind == 0) ep = t;
      if (perf && kind == 1) er = t;
      if (perf && kind == 2) ei = t;
      if (perf && ix < 2) t += s + 1;
    end
    lat = t;
    np = on ? (bp & ~mp[dom]) : (bp | mp[dom]);
    nr = on ? (br | mr[dom]) : (br & ~mr[dom]);
    ni = on ? (bi | mi[dom]) : (bi & ~mi[dom]);
    if (np == bp) ep = -1;
    if (nr == br) er = -1;
    if (ni == bi) ei = -1;
    gp = -1; gi = -1; gr = -1;
    pp = pwr_vec; pi = iso_vec; pr = rst_vec;
    settle = s[CW-1:0];
    req_dom = dom[1:0]; req_on = on; req_valid = 1'b1;
    @(posedge clk); #2;
    req_valid = 1'b0;
    chk(busy == 1'b1, {tag, " R8 busy after accept"}, busy, 1);
    k = 0; seen = 0;
    while (!seen && k < 300) begin
      @(posedge clk); #2;
      k++;
      if (pwr_vec != pp && gp < 0) gp = k;
      if (iso_vec != pi && gi < 0) gi = k;
      if (rst_vec != pr && gr < 0) gr = k;
      pp = pwr_vec; pi = iso_vec; pr = rst_vec;
      if (done) seen = 1;
      else if (!busy) begin
        chk(0, {tag, " R8 busy dropped early"}, k, lat);
        k = 300;
      end
      if (inject && k == 2) begin
        req_dom = 2'd2; req_on = 1'b0; req_valid = 1'b1;
      end else req_valid = 1'b0;
    end
    req_valid = 1'b0;
    chk(k == lat, {tag, " R7 latency to done"}, k, lat);
    chk(busy == 1'b0, {tag, " R8 busy low with done"}, busy, 0);
    chk(gp == ep, {tag, " R2/R3 pwr step cycle"}, gp, ep);
    chk(gr == er, {tag, " R2/R3 rst step cycle"}, gr, er);
    chk(gi == ei, {tag, " R5 iso step cycle"}, gi, ei);
    bp = np; bi = ni; br = nr;
    chk_state(tag);
    @(posedge clk); #2;
    chk(done == 1'b0, {tag, " R8 done one cycle"}, done, 0);
  endtask

  initial begin
    mp[0] = 8'h03; mi[0] = 8'h01; mr[0] = 8'h04;
    mp[1] = 8'h08; mi[1] = 8'h02; mr[1] = 8'h10;
    mp[2] = 8'h20; mi[2] = 8'h00; mr[2] = 8'h00;
    mp[3] = 8'h00; mi[3] = 8'h40; mr[3] = 8'h80;
    for (int d = 0; d < ND; d++) begin
      pwr_cfg[d*VW +: VW] = mp[d];
      iso_cfg[d*VW +: VW] = mi[d];
      rst_cfg[d*VW +: VW] = mr[d];
    end
    bp = 8'h00; bi = 8'hFF; br = 8'hFF;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk(busy == 0 && done == 0 && err == 0, "R1 busy/done/err after reset", {busy, done, err}, 0);
    chk_state("R1 reset");
    rst_n = 1'b1;
    @(posedge clk); #2;
    run_seq(0, 0, 2, 0, "R2 d0 off s2");
    run_seq(1, 0, 0, 0, "R6 d1 off s0");
    run_seq(0, 1, 3, 0, "R3 d0 on s3");
    run_seq(2, 0, 1, 0, "R5 d2 off skips");
    run_seq(2, 1, 0, 0, "R5 d2 on skips");
    run_seq(3, 0, 1, 0, "R10 d3 off empty pwr");
    chk(err == 1'b0, "R9 err clear before drop", err, 0);
    run_seq(1, 1, 1, 1, "R9 d1 on with drop");
    chk(err == 1'b1, "R9 err sticky after drop", err, 1);
    err_clr = 1'b1;
    @(posedge clk); #2;
    err_clr = 1'b0;
    chk(err == 1'b0, "R9 err cleared", err, 0);
    run_seq(3, 1, 0, 0, "R3 d3 on");
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule